// File: doc/BRIEF.md
# Parallel Instruction Start Finder

This block takes one 16-byte fetch window of variable-length instruction bytes and finds the bytes where instructions really begin. An earlier stage has already computed, for every byte offset, the length an instruction would have if it started at that byte. The block chains these speculative lengths from the window's entry offset. The chain is resolved with a log-depth doubling network and not with a serial walk. The set of real starts is registered. The second stage packs the starts in ascending order into six output slots, each slot giving an offset and a length.

When a window holds more than six starts, the block emits a full batch with a stall flag. It keeps the rest of the window and sends the remaining starts in later batches, while it holds off new input. An instruction that runs past byte 15 leaves a carry offset. The block keeps this offset and uses it as the entry of the next window, unless the input forces a fresh entry (for example after a redirect). A zero length on a real start flags the window as erroneous.

Top module: `insn_start_marker`

## Requirements
- R1: A synchronous active-high reset empties the pipeline (`out_valid` low, `in_ready` high) and clears the carried entry to 0.
- R2: An accepted window starts at `in_entry` when `in_redirect` is 1, and at the carried offset of the previous window otherwise.
- R3: Offset i is a start if it is the entry, or if an earlier start s has s + len(s) = i. Offsets below the entry and lengths at non-start offsets have no effect. The length for offset i is `in_len[4i+3:4i]`.
- R4: `out_err` is 1 for every batch of a window in which some start has length 0. Zero lengths at non-start offsets do not raise it. After an erroneous window the carried entry becomes 0.
- R5: `out_carry` equals last start + its length − 16. This value becomes the carried entry.
- R6: Slot j uses `out_off[4j+3:4j]` and `out_len[4j+3:4j]`. Valid slots form a contiguous run from slot 0 and hold the starts in ascending offset order.
- R7: A window with more than 6 starts first gives batches of 6 with `out_stall` set. A final batch with `out_stall` clear follows, picking up at the seventh start. No new window is accepted until that final batch moves out.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R9: With the output free, the first batch of a window appears on the outputs after the second rising edge following acceptance.
- R10: A window with exactly 6 starts gives one batch with all slots valid and `out_stall` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Window can be taken |
| in_len | input | 64 | Candidate length per byte offset, 4 bits each |
| in_redirect | input | 1 | Use `in_entry` and ignore the carried entry |
| in_entry | input | 4 | Forced entry offset |
| out_valid | output | 1 | Batch present |
| out_ready | input | 1 | Consumer takes the batch |
| out_off | output | 24 | Start offset per slot |
| out_len | output | 24 | Instruction length per slot |
| out_slot_vld | output | 6 | Per-slot valid |
| out_stall | output | 1 | More starts of this window follow |
| out_err | output | 1 | Zero length found on a start |
| out_carry | output | 4 | Entry offset for the next window |

## Verification
The checks assume that lengths at non-start offsets may hold any value, including 0. Strict offset ordering and nonzero slot lengths are only claimed when `out_err` is clear. The stimulus therefore puts decoy and zero lengths only on bytes the chain skips, and puts a zero length on a real start only in the window that tests the error flag. The input is held stable while `in_valid` waits for `in_ready`. `out_ready` is only dropped while a batch waits, so the hold property is exercised on a stalled window.

// File: rtl/insn_start_marker.sv
module insn_start_marker #(
  parameter int WIN   = 16,
  parameter int SLOTS = 6,
  parameter int LW    = 4,
  localparam int OW   = $clog2(WIN),
  localparam int PW   = OW + 1,
  localparam int LVL  = $clog2(WIN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WIN*LW-1:0]     in_len,
  input  logic                  in_redirect,
  input  logic [OW-1:0]         in_entry,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SLOTS*OW-1:0]   out_off,
  output logic [SLOTS*LW-1:0]   out_len,
  output logic [SLOTS-1:0]      out_slot_vld,
  output logic                  out_stall,
  output logic                  out_err,
  output logic [OW-1:0]         out_carry
);

  logic [OW-1:0] carry_q;
  logic [OW-1:0] entry;
  assign entry = in_redirect ? in_entry : carry_q;

  // doubling network: jp = node reached after 2^k steps, rc = nodes seen in fewer steps
  for (genvar k = 0; k <= LVL; k++) begin : g_lvl
    logic [PW-1:0]  jp [WIN+1];
    logic [WIN-1:0] rc [WIN+1];
    if (k == 0) begin : g_base
      always_comb begin
        for (int i = 0; i < WIN; i++) begin
          logic [PW-1:0] s;
          s = PW'(i) + PW'(in_len[i*LW +: LW]);
          jp[i] = (s >= PW'(WIN)) ? PW'(WIN) : s;
          rc[i] = WIN'(1) << i;
        end
        jp[WIN] = PW'(WIN);
        rc[WIN] = '0;
      end
    end else begin : g_step
      always_comb begin
        for (int i = 0; i <= WIN; i++) begin
          jp[i] = g_lvl[k-1].jp[g_lvl[k-1].jp[i]];
          rc[i] = g_lvl[k-1].rc[i] | g_lvl[k-1].rc[g_lvl[k-1].jp[i]];
        end
      end
    end
  end

  logic [WIN-1:0] mask;
  logic [OW-1:0]  last;
  logic [PW-1:0]  end_pos;
  logic           err;
  logic [OW-1:0]  nxt_carry;

  assign mask = g_lvl[LVL].rc[entry];

  always_comb begin
    last = '0;
    err  = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      if (mask[i]) begin
        last = OW'(i);
        if (in_len[i*LW +: LW] == '0) err = 1'b1;
      end
    end
    end_pos   = PW'(last) + PW'(in_len[last*LW +: LW]);
    nxt_carry = err ? '0 : OW'(end_pos - PW'(WIN));
  end

  logic              s1_valid;
  logic [WIN-1:0]    s1_mask;
  logic [WIN*LW-1:0] s1_len;
  logic              s1_err;
  logic [OW-1:0]     s1_carry;

  logic [SLOTS*OW-1:0] pk_off;
  logic [SLOTS*LW-1:0] pk_len;
  logic [SLOTS-1:0]    pk_vld;
  logic [WIN-1:0]      taken;

  // slot c takes the start whose count of lower starts equals c
  always_comb begin
    int c;
    c = 0;
    pk_off = '0;
    pk_len = '0;
    pk_vld = '0;
    taken  = '0;
    for (int i = 0; i < WIN; i++) begin
      if (s1_mask[i]) begin
        if (c < SLOTS) begin
          pk_off[c*OW +: OW] = OW'(i);
          pk_len[c*LW +: LW] = s1_len[i*LW +: LW];
          pk_vld[c] = 1'b1;
          taken[i]  = 1'b1;
        end
        c = c + 1;
      end
    end
  end

  logic [WIN-1:0] rem;
  logic last_batch, out_adv, drain, accept;

  assign rem        = s1_mask & ~taken;
  assign last_batch = (rem == '0);
  assign out_adv    = !out_valid || out_ready;
  assign drain      = s1_valid && out_adv;
  assign in_ready   = !s1_valid || (drain && last_batch);
  assign accept     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q   <= '0;
      s1_valid  <= 1'b0;
      s1_mask   <= '0;
      s1_len    <= '0;
      s1_err    <= 1'b0;
      s1_carry  <= '0;
      out_valid <= 1'b0;
      out_off   <= '0;
      out_len   <= '0;
      out_slot_vld <= '0;
      out_stall <= 1'b0;
      out_err   <= 1'b0;
      out_carry <= '0;
    end else begin
      if (accept) begin
        s1_valid <= 1'b1;
        s1_mask  <= mask;
        s1_len   <= in_len;
        s1_err   <= err;
        s1_carry <= nxt_carry;
        carry_q  <= nxt_carry;
      end else if (drain) begin
        if (last_batch) s1_valid <= 1'b0;
        else            s1_mask  <= rem;
      end
      if (out_adv) begin
        out_valid <= s1_valid;
        if (s1_valid) begin
          out_off      <= pk_off;
          out_len      <= pk_len;
          out_slot_vld <= pk_vld;
          out_stall    <= !last_batch;
          out_err      <= s1_err;
          out_carry    <= s1_carry;
        end
      end
    end
  end

endmodule

// File: rtl/insn_start_marker_chk.sv
module insn_start_marker_chk #(
  parameter int WIN   = 16,
  parameter int SLOTS = 6,
  parameter int LW    = 4,
  localparam int OW   = $clog2(WIN)
) (
  input logic                clk,
  input logic                rst,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SLOTS*OW-1:0] out_off,
  input logic [SLOTS*LW-1:0] out_len,
  input logic [SLOTS-1:0]    out_slot_vld,
  input logic                out_stall,
  input logic                out_err,
  input logic [OW-1:0]       out_carry
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_off) && $stable(out_len)
      && $stable(out_slot_vld) && $stable(out_stall) && $stable(out_err) && $stable(out_carry));

  assert_dense_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot_vld & (out_slot_vld + SLOTS'(1))) == '0);

  assert_full_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_stall |-> &out_slot_vld);

  assert_entry_start_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_slot_vld[0]);

  always @(posedge clk) begin
    if (!rst && out_valid && !out_err) begin
      for (int j = 0; j < SLOTS; j++) begin
        if (out_slot_vld[j]) begin
          assert_len_nonzero_R4: assert (out_len[j*LW +: LW] != '0);
          if (j > 0) begin
            assert_order_R6: assert (out_off[j*OW +: OW] > out_off[(j-1)*OW +: OW]);
          end
        end
      end
    end
  end

endmodule

bind insn_start_marker insn_start_marker_chk #(.WIN(WIN), .SLOTS(SLOTS), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_off(out_off), .out_len(out_len), .out_slot_vld(out_slot_vld),
  .out_stall(out_stall), .out_err(out_err), .out_carry(out_carry));

// File: tb/insn_start_marker_test.sv
module insn_start_marker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_redirect = 1'b0, out_ready = 1'b1;
  logic [63:0] in_len = '0;
  logic [3:0]  in_entry = '0;
  logic in_ready, out_valid, out_stall, out_err;
  logic [23:0] out_off, out_len;
  logic [5:0]  out_slot_vld;
  logic [3:0]  out_carry;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_start_marker uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
    .in_redirect(in_redirect), .in_entry(in_entry), .out_valid(out_valid),
    .out_ready(out_ready), .out_off(out_off), .out_len(out_len),
    .out_slot_vld(out_slot_vld), .out_stall(out_stall), .out_err(out_err),
    .out_carry(out_carry));

  // {lens, redirect, entry, expected start mask, expected carry, expected err}
  localparam logic [89:0] VEC [9] = '{
    {64'h1111_1111_1111_1111, 1'b1, 4'd0, 16'hFFFF, 4'd0, 1'b0},
    {64'h4444_4444_4444_4444, 1'b0, 4'd9, 16'h1111, 4'd0, 1'b0},
    {64'hFFF6_FFFF_FF7F_F3FF, 1'b1, 4'd2, 16'h1024, 4'd2, 1'b0},
    {64'h2222_2222_2222_2222, 1'b0, 4'd0, 16'h5554, 4'd0, 1'b0},
    {64'h8111_1111_1111_111F, 1'b0, 4'd0, 16'h8001, 4'd7, 1'b0},
    {64'h0000_0000_9000_0000, 1'b0, 4'd3, 16'h0080, 4'd0, 1'b0},
    {64'h1111_1111_1101_2111, 1'b1, 4'd3, 16'h0028, 4'd0, 1'b1},
    {64'h3333_3333_3333_3333, 1'b0, 4'd0, 16'h9249, 4'd2, 1'b0},
    {64'h5555_5555_5555_5555, 1'b0, 4'd0, 16'h1084, 4'd1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] lens, input logic redir, input logic [3:0] ent);
    bit acc;
    @(negedge clk);
    in_len = lens; in_redirect = redir; in_entry = ent; in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      acc = in_ready;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // at a negedge after acceptance; returns number of batches seen
  task automatic collect(input logic [63:0] lens, input logic [15:0] mask, input logic [3:0] carry,
                         input logic err, input string req, output int batches);
    logic [15:0] rem;
    bit more;
    rem = mask;
    batches = 0;
    more = 1'b1;
    while (more) begin
      logic [23:0] e_off, e_len, m;
      logic [5:0]  e_vld;
      while (!out_valid) @(negedge clk);
      e_off = '0; e_len = '0; e_vld = '0; m = '0;
      for (int j = 0; j < 6; j++) begin
        for (int i = 0; i < 16; i++) begin
          if (rem[i] && !e_vld[j]) begin
            e_vld[j] = 1'b1;
            e_off[j*4 +: 4] = 4'(i);
            e_len[j*4 +: 4] = lens[i*4 +: 4];
            m[j*4 +: 4] = 4'hF;
            rem[i] = 1'b0;
          end
        end
      end
      more = (rem != '0);
      check(out_slot_vld == e_vld, {req, " R3 R6 slot valid"}, 64'(out_slot_vld), 64'(e_vld));
      check((out_off & m) == e_off, {req, " R2 R3 R6 offsets"}, 64'(out_off & m), 64'(e_off));
      check((out_len & m) == e_len, {req, " R6 lengths"}, 64'(out_len & m), 64'(e_len));
      check(out_stall == more, {req, " R7 stall"}, 64'(out_stall), 64'(more));
      check(out_err == err, {req, " R4 error"}, 64'(out_err), 64'(err));
      if (!more && !err)
        check(out_carry == carry, {req, " R5 carry"}, 64'(out_carry), 64'(carry));
      batches++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int nb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 1);
    rst = 1'b0;

    // R8: hold while the consumer stalls, on the 16-start window
    out_ready = 1'b0;
    send(VEC[0][89:26], VEC[0][25], VEC[0][24:21]);
    repeat (3) @(negedge clk);
    begin
      logic [23:0] o1; logic [5:0] v1; logic s1;
      o1 = out_off; v1 = out_slot_vld; s1 = out_stall;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1, "R8 valid held", 64'(out_valid), 1);
      check(out_off == o1 && out_slot_vld == v1 && out_stall == s1, "R8 outputs held",
            64'(out_off), 64'(o1));
      check(in_ready == 1'b0, "R7 no new window while stalled", 64'(in_ready), 0);
    end
    out_ready = 1'b1;
    collect(VEC[0][89:26], VEC[0][20:5], VEC[0][4:1], VEC[0][0], "V0", nb);
    check(nb == 3, "R7 batches for 16 starts", 64'(nb), 3);

    // table walk, entries chained through the carried offset
    for (int v = 1; v < 9; v++) begin
      send(VEC[v][89:26], VEC[v][25], VEC[v][24:21]);
      if (v == 1) begin
        check(out_valid == 1'b0, "R9 one edge after accept", 64'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 two edges after accept", 64'(out_valid), 1);
      end
      collect(VEC[v][89:26], VEC[v][20:5], VEC[v][4:1], VEC[v][0], $sformatf("V%0d", v), nb);
      if (v == 3) check(nb == 2, "R7 seven starts give two batches", 64'(nb), 2);
      if (v == 7) check(nb == 1, "R10 six starts in one batch", 64'(nb), 1);
    end

    // R1: reset clears the carried entry (carry is 1 before this)
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after mid-run reset", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after mid-run reset", 64'(in_ready), 1);
    rst = 1'b0;
    send(64'h4444_4444_4444_4444, 1'b0, 4'd5);
    collect(64'h4444_4444_4444_4444, 16'h1111, 4'd0, 1'b0, "R1 R2 entry after reset", nb);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule